// File: doc/BRIEF.md
# Dual-Read Register File with Null Identifier

This block holds the working registers of a small datapath: fifteen 64-bit words, each named by a 4-bit identifier. Two read ports return stored words without waiting for a clock. A single write port stores a word on the rising clock edge. All three ports can work in the same cycle, each with its own identifier.

Identifier 0xF is the null identifier. A write aimed at it is dropped. A read port given it returns zero instead of a stored word. Control logic can therefore leave any port idle by driving 0xF, with no separate enable pin. The stored words have no reset, so each register holds an unknown value until it is first written.

Top module: `dual_read_regfile`

## Requirements
- R1: Identifiers 0x0 to 0xE each select their own 64-bit register, and a word written to one of them reads back unchanged.
- R2: A read port's data follows its identifier combinationally: it changes within the same clock phase, with no clock edge.
- R3: A write changes the stored word only at a rising edge of `clk`; before that edge, reads return the previous contents.
- R4: A write with `wr_id` = 0xF leaves every register unchanged.
- R5: A read port whose identifier is 0xF returns all-zero data.
- R6: The two read ports are independent: any pair of identifiers, the same identifier on both included, returns the correct word on each port.
- R7: A read of the register being written in the same cycle returns the old word until the rising edge and the new word after it.
- R8: A write to one register leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rd_a_id | input | 4 | Identifier for read port A (0xF = none) |
| rd_a_data | output | 64 | Word read on port A; zero when `rd_a_id` is 0xF |
| rd_b_id | input | 4 | Identifier for read port B (0xF = none) |
| rd_b_data | output | 64 | Word read on port B; zero when `rd_b_id` is 0xF |
| wr_id | input | 4 | Identifier for the write port (0xF = no write) |
| wr_data | input | 64 | Word stored at the rising edge |

## Verification
Read results are due in zero cycles: the bench changes a read identifier on the falling edge and checks the data 1 ns later, with no rising edge in between. Write results are due one rising edge later. The bench sets up a write on a falling edge and checks the old word before the next rising edge. It then checks the new word 1 ns after that edge. A full sweep of all 256 identifier pairs on both ports, done with writes idle, checks the two ports against an arithmetic model of every register held in the bench.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ID_W   = 4;
  localparam int unsigned RF_DATA_W = 64;
  localparam int unsigned RF_REGS   = 15;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned ID_W    = rf_pkg::RF_ID_W,
  parameter int unsigned REG_CNT = rf_pkg::RF_REGS
) (
  input  logic [ID_W-1:0]    wr_id,
  output logic [REG_CNT-1:0] wr_sel
);
  localparam logic [ID_W-1:0] NULL_ID = '1;

  always_comb begin
    wr_sel = '0;
    for (int k = 0; k < int'(REG_CNT); k++) begin
      if (wr_id == ID_W'(k)) wr_sel[k] = 1'b1;
    end
  end

  always_comb begin
    if (!$isunknown(wr_id)) begin
      AST_WR_SEL_ONEHOT0: assert ($onehot0(wr_sel)); // R8
      if (wr_id == NULL_ID) begin
        AST_WR_NULL_IDLE: assert (wr_sel == '0); // R4
      end
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W  = rf_pkg::RF_DATA_W,
  parameter int unsigned REG_CNT = rf_pkg::RF_REGS
) (
  input  logic                           clk,
  input  logic [REG_CNT-1:0]             wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [REG_CNT-1:0][DATA_W-1:0] regs_q
);
  for (genvar g = 0; g < int'(REG_CNT); g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wr_sel[g]) regs_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned ID_W    = rf_pkg::RF_ID_W,
  parameter int unsigned DATA_W  = rf_pkg::RF_DATA_W,
  parameter int unsigned REG_CNT = rf_pkg::RF_REGS
) (
  input  logic [ID_W-1:0]                rd_id,
  input  logic [REG_CNT-1:0][DATA_W-1:0] regs_q,
  output logic [DATA_W-1:0]              rd_data
);
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < int'(REG_CNT); k++) begin
      if (rd_id == ID_W'(k)) rd_data = regs_q[k];
    end
  end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int unsigned ID_W    = rf_pkg::RF_ID_W,
  parameter int unsigned DATA_W  = rf_pkg::RF_DATA_W,
  parameter int unsigned REG_CNT = rf_pkg::RF_REGS
) (
  input  logic              clk,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned      PORTS   = 2;
  localparam logic [ID_W-1:0] NULL_ID = '1;

  logic [REG_CNT-1:0]             wr_sel;
  logic [REG_CNT-1:0][DATA_W-1:0] regs_q;
  logic [PORTS-1:0][ID_W-1:0]     rd_ids;
  logic [PORTS-1:0][DATA_W-1:0]   rd_datas;

  assign rd_ids[0] = rd_a_id;
  assign rd_ids[1] = rd_b_id;
  assign rd_a_data = rd_datas[0];
  assign rd_b_data = rd_datas[1];

  rf_wr_decode #(.ID_W(ID_W), .REG_CNT(REG_CNT)) u_dec (
    .wr_id  (wr_id),
    .wr_sel (wr_sel)
  );

  rf_storage #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_store (
    .clk     (clk),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  for (genvar p = 0; p < int'(PORTS); p++) begin : g_port
    rf_read_port #(.ID_W(ID_W), .DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rd (
      .rd_id   (rd_ids[p]),
      .regs_q  (regs_q),
      .rd_data (rd_datas[p])
    );
  end

  always_comb begin
    if (!$isunknown(rd_a_id) && rd_a_id == NULL_ID) begin
      AST_RDA_NULL_ZERO: assert (rd_a_data == '0); // R5
    end
    if (!$isunknown(rd_b_id) && rd_b_id == NULL_ID) begin
      AST_RDB_NULL_ZERO: assert (rd_b_data == '0); // R5
    end
    if (!$isunknown(rd_a_id) && !$isunknown(rd_b_id) && rd_a_id == rd_b_id) begin
      AST_SAME_ID_SAME_DATA: assert (rd_a_data === rd_b_data); // R6
    end
  end
endmodule

// File: tb/test_dual_read_regfile.sv
`timescale 1ns/1ps
module test_dual_read_regfile;
  localparam int NREG = 15;

  logic        clk = 1'b0;
  logic [3:0]  rd_a_id = 4'hF, rd_b_id = 4'hF, wr_id = 4'hF;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic [63:0] model [NREG];
  int vectors = 0, misses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_read_regfile i_dual_read_regfile (
    .clk(clk), .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
    .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
    .wr_id(wr_id), .wr_data(wr_data)
  );

  function automatic logic [63:0] pat(input int i, input int seed);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1)) ^ {32'(seed), 32'(i)};
  endfunction

  function automatic logic [63:0] expect_of(input logic [3:0] id);
    return (id == 4'hF) ? 64'h0 : model[id];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] id, input logic [63:0] d);
    @(negedge clk);
    wr_id = id; wr_data = d;
    @(posedge clk); #1;
    if (id != 4'hF) model[id] = d;
    @(negedge clk);
    wr_id = 4'hF;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R5: initial state, null reads give zero
    @(negedge clk); #1;
    chk("R5 null A at start", rd_a_data, 64'h0);
    chk("R5 null B at start", rd_b_data, 64'h0);

    // R1: fill every register
    for (int i = 0; i < NREG; i++) do_write(4'(i), pat(i, 1));
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); rd_a_id = 4'(i); #1;
      chk("R1 readback", rd_a_data, model[i]);
    end

    // R2 R5 R6: all pairs of identifiers, no clock edge between set and check
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        rd_a_id = 4'(a); rd_b_id = 4'(b); #1;
        chk("R6 port A", rd_a_data, expect_of(4'(a)));
        chk("R6 port B", rd_b_data, expect_of(4'(b)));
        rd_a_id = 4'(b); #1;
        chk("R2 comb follow", rd_a_data, expect_of(4'(b)));
      end
    end

    // R4: writes to the null identifier are dropped
    for (int s = 0; s < 4; s++) do_write(4'hF, pat(s, 77));
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); rd_a_id = 4'(i); rd_b_id = 4'hF; #1;
      chk("R4 null write no effect", rd_a_data, model[i]);
      chk("R5 null read", rd_b_data, 64'h0);
    end

    // R3 R7 R8: write timing, same-cycle read of the written register
    for (int w = 0; w < NREG; w++) begin
      logic [63:0] oldv, newv;
      int other;
      other = (w + 7) % NREG;
      oldv = model[w]; newv = pat(w, 500 + w);
      @(negedge clk);
      wr_id = 4'(w); wr_data = newv; rd_a_id = 4'(w); rd_b_id = 4'(other); #1;
      chk("R3 old before edge", rd_a_data, oldv);
      @(posedge clk); #1;
      model[w] = newv;
      chk("R7 new after edge", rd_a_data, newv);
      chk("R8 neighbour kept", rd_b_data, model[other]);
      @(negedge clk); wr_id = 4'hF;
    end
    for (int i = 0; i < NREG; i++) begin
      @(negedge clk); rd_b_id = 4'(i); #1;
      chk("R8 final contents", rd_b_data, model[i]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule